// File: doc/BRIEF.md
# Serial Transceiver with One Shared Data Register

This block is an asynchronous serial transmitter and receiver. The byte the host sends and the byte the line delivers share one physical holding register. A host write puts a byte into that register. The byte is then handed to a hidden transmit shifter and sent least significant bit first. The receiver collects line bits in its own hidden shifter and then copies the finished byte into the same register, where the host reads it.

Bit timing comes from an external tick that runs at sixteen times the bit rate. Three enable bits control the pins: global, transmit and receive. The transmit driver is active only when the global and transmit bits are both set; otherwise its output enable is low. The receive input is listened to only when the global and receive bits are both set. Status outputs report the following:
- the transmit register is empty;
- unread receive data is waiting;
- a framing error occurred;
- unread data was overwritten (overrun).

Because there is only one register, a host byte that is still waiting to be sent has priority. A completed receive byte stays in its shifter until the host byte has moved out of the register.

Top module: `uart_shared_buf`

## Requirements
- R1: `cfg_wdata` bit 0 is the global enable, bit 1 the transmit enable and bit 2 the receive enable. They are written by pulsing `cfg_wr`. `tx_oe` is 1 only while the global and transmit enables are both 1, and it changes one cycle after the write. While `tx_oe` is 0, `tx_out` is held at 1, any frame in progress stops, and a pending host byte is not sent.
- R2: The receiver ignores `rx_in` unless the global and receive enables are both 1. A frame sent while the receiver is disabled leaves `rx_ready` and `host_rdata` unchanged.
- R3: A transmitted frame has one low start bit, then 8 data bits least significant first, then one high stop bit. Each bit lasts 16 `baud_tick` pulses, and the line idles high.
- R4: A host write loads the shared register and clears `tx_empty`. When the transmitter is idle and enabled, the byte moves to the transmit shifter and `tx_empty` returns to 1.
- R5: The receiver starts on a falling edge, confirms the start bit at mid-bit and samples each data bit at mid-bit. It then copies the byte into the shared register, sets `rx_ready`, and the byte appears on `host_rdata`.
- R6: A pulse on `host_rd` clears `rx_ready`, `frame_err` and `overrun`.
- R7: A stop bit sampled low sets `frame_err`. The byte is still delivered.
- R8: If a received byte is copied while `rx_ready` is already 1, `overrun` is set and the newer byte is kept.
- R9: While a host byte waits to be sent, a completed receive byte is not copied, so the register keeps the host byte and `rx_ready` stays 0. The receive byte is copied only after the host byte has moved to the transmit shifter.
- R10: After reset, the state is:
  - `tx_empty` = 1;
  - `rx_ready`, `frame_err`, `overrun` and `tx_oe` = 0;
  - `tx_out` = 1;
  - `host_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write pulse for the shared data register |
| host_wdata | input | 8 | Byte to transmit |
| host_rd | input | 1 | Read pulse; clears the receive status flags |
| host_rdata | output | 8 | Contents of the shared data register |
| cfg_wr | input | 1 | Write pulse for the enable bits |
| cfg_wdata | input | 3 | {receive, transmit, global} enables |
| tx_empty | output | 1 | No host byte is waiting in the shared register |
| rx_ready | output | 1 | Unread receive byte is in the shared register |
| frame_err | output | 1 | Stop bit of a received byte was low |
| overrun | output | 1 | Unread receive byte was overwritten |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_out | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Drive enable for the transmit pin |
| rx_in | input | 1 | Serial receive data |

## Verification
The main corner case is the shared-register conflict. A host byte is left waiting with the transmitter disabled while a frame arrives. A design without the priority rule would overwrite the host byte and then send the received value, or would set `rx_ready` too early. The bench also sends frames with a low stop bit, and back-to-back frames without a read in between. A wrong design would drop the errored byte, or would fail to flag the overrun and keep the older byte. Frames are also sent while the global enable is off or the receiver is disabled. A design that ignored the combined enables would drive the line or capture that traffic.

// File: rtl/uart_sb_pkg.sv
package uart_sb_pkg;
  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_STOP  = 3'd3,
    RX_FULL  = 3'd4
  } rx_state_e;

  localparam int CFG_W   = 3;
  localparam int CFG_GLB = 0;
  localparam int CFG_TX  = 1;
  localparam int CFG_RX  = 2;
endpackage

// File: rtl/uart_sb_tx.sv
module uart_sb_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic              idle,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(OVS);
  localparam int IDX_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic               busy_q;
  logic               txd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      txd_q   <= 1'b1;
    end else if (!en) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
    end else if (load) begin
      frame_q <= {1'b1, din, 1'b0};
      cnt_q   <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b1;
      txd_q   <= 1'b0;
    end else if (busy_q && tick) begin
      if (cnt_q == CNT_W'(OVS - 1)) begin
        cnt_q <= '0;
        if (idx_q == IDX_W'(FRAME_W - 1)) begin
          busy_q <= 1'b0;
          txd_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
          txd_q <= frame_q[idx_q + 1'b1];
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign idle = !busy_q;
  assign txd  = txd_q;

  // R3: a frame opens with a low start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !txd_q);
  // R3: the line returns high when a frame ends
  a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> txd_q);
endmodule

// File: rtl/uart_sb_rx.sv
module uart_sb_rx
  import uart_sb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              rxd,
  input  logic              ack,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              ferr
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int HALF  = OVS / 2 - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   line;
  rx_state_e              st_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [IDX_W-1:0]       idx_q;
  logic [DATA_W-1:0]      sh_q;
  logic                   ferr_q;

  assign line = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      prev_q <= line;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      ferr_q <= 1'b0;
    end else if (!en) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (prev_q && !line) st_q <= RX_START;
        end
        RX_START: if (tick) begin
          if (cnt_q == CNT_W'(HALF)) begin
            cnt_q <= '0;
            idx_q <= '0;
            st_q  <= line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (cnt_q == CNT_W'(OVS - 1)) begin
            cnt_q <= '0;
            sh_q  <= {line, sh_q[DATA_W-1:1]};
            if (idx_q == IDX_W'(DATA_W - 1)) st_q <= RX_STOP;
            else idx_q <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (cnt_q == CNT_W'(OVS - 1)) begin
            cnt_q  <= '0;
            ferr_q <= !line;
            st_q   <= RX_FULL;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_FULL: if (ack) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign full = (st_q == RX_FULL);
  assign data = sh_q;
  assign ferr = ferr_q;

  // R2: a disabled receiver returns to idle
  a_r2_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> st_q == RX_IDLE);
  // R9: a finished byte is held until it is copied
  a_r9_hold_full: assert property (@(posedge clk) disable iff (rst)
    (st_q == RX_FULL && !ack && en) |=> (st_q == RX_FULL && $stable(sh_q)));
endmodule

// File: rtl/uart_shared_buf.sv
module uart_shared_buf
  import uart_sb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              tx_empty,
  output logic              rx_ready,
  output logic              frame_err,
  output logic              overrun,
  input  logic              baud_tick,
  output logic              tx_out,
  output logic              tx_oe,
  input  logic              rx_in
);
  logic              tx_oe_q, rx_act_q;
  logic [DATA_W-1:0] data_q;
  logic              tx_pend_q, rx_rdy_q, ferr_q, ovr_q;
  logic              tx_idle, tx_load, rx_copy;
  logic              rx_full, rx_ferr;
  logic [DATA_W-1:0] rx_byte;

  assign tx_load = tx_pend_q && tx_idle && tx_oe_q;
  assign rx_copy = rx_full && !tx_pend_q && !host_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_oe_q  <= 1'b0;
      rx_act_q <= 1'b0;
    end else if (cfg_wr) begin
      tx_oe_q  <= cfg_wdata[CFG_GLB] & cfg_wdata[CFG_TX];
      rx_act_q <= cfg_wdata[CFG_GLB] & cfg_wdata[CFG_RX];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      tx_pend_q <= 1'b0;
      rx_rdy_q  <= 1'b0;
      ferr_q    <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (host_wr)      data_q <= host_wdata;
      else if (rx_copy) data_q <= rx_byte;

      if (host_wr)      tx_pend_q <= 1'b1;
      else if (tx_load) tx_pend_q <= 1'b0;

      if (rx_copy)      rx_rdy_q <= 1'b1;
      else if (host_rd) rx_rdy_q <= 1'b0;

      if (rx_copy && rx_ferr) ferr_q <= 1'b1;
      else if (host_rd)       ferr_q <= 1'b0;

      if (rx_copy && rx_rdy_q && !host_rd) ovr_q <= 1'b1;
      else if (host_rd)                    ovr_q <= 1'b0;
    end
  end

  uart_sb_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .en(tx_oe_q), .tick(baud_tick),
    .load(tx_load), .din(data_q), .idle(tx_idle), .txd(tx_out)
  );

  uart_sb_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .en(rx_act_q), .tick(baud_tick), .rxd(rx_in),
    .ack(rx_copy), .full(rx_full), .data(rx_byte), .ferr(rx_ferr)
  );

  assign host_rdata = data_q;
  assign tx_empty   = !tx_pend_q;
  assign rx_ready   = rx_rdy_q;
  assign frame_err  = ferr_q;
  assign overrun    = ovr_q;
  assign tx_oe      = tx_oe_q;

  // R1: the line rests high while the driver is off
  a_r1_off_high: assert property (@(posedge clk) disable iff (rst)
    !tx_oe_q |=> tx_out);
  // R4: a byte handed to the shifter frees the register
  a_r4_empty_after_load: assert property (@(posedge clk) disable iff (rst)
    (tx_load && !host_wr) |=> tx_empty);
  // R5: a copied byte shows up on the read port with the ready flag
  a_r5_copy_visible: assert property (@(posedge clk) disable iff (rst)
    rx_copy |=> (host_rdata == $past(rx_byte) && rx_ready));
  // R6: a read clears the receive status
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !rx_copy) |=> (!rx_ready && !overrun && !frame_err));
  // R8: copying over unread data flags an overrun
  a_r8_overrun: assert property (@(posedge clk) disable iff (rst)
    (rx_copy && rx_ready && !host_rd) |=> overrun);
  // R9: a waiting host byte is never overwritten by received data
  a_r9_pending_kept: assert property (@(posedge clk) disable iff (rst)
    (!tx_empty && !host_wr && !tx_load) |=> $stable(host_rdata));
endmodule

// File: tb/sim_uart_shared_buf.sv
module sim_uart_shared_buf;
  localparam int CLK_P    = 10;
  localparam int TICK_DIV = 4;
  localparam int BIT      = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0, cfg_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [2:0] cfg_wdata = '0;
  logic       baud_tick = 1'b0;
  logic       rx_in = 1'b1;
  logic [7:0] host_rdata;
  logic       tx_empty, rx_ready, frame_err, overrun, tx_out, tx_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  uart_shared_buf u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .tx_empty(tx_empty), .rx_ready(rx_ready),
    .frame_err(frame_err), .overrun(overrun), .baud_tick(baud_tick),
    .tx_out(tx_out), .tx_oe(tx_oe), .rx_in(rx_in)
  );

  always #(CLK_P / 2) clk = ~clk;

  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n = (n + 1) % TICK_DIV;
      baud_tick = (n == 0);
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [2:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic hwrite(logic [7:0] b);
    exp_q.push_back(b);
    @(negedge clk); host_wr = 1'b1; host_wdata = b;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hread();
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic send(logic [7:0] b, logic stop);
    @(negedge clk); rx_in = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_in = b[i];
      repeat (BIT) @(negedge clk);
    end
    rx_in = stop;
    repeat (BIT) @(negedge clk);
    rx_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // monitor: decode frames on tx_out and compare against the scoreboard (R3)
  initial begin
    logic prev = 1'b1;
    logic [7:0] got;
    logic [7:0] exp;
    forever begin
      @(negedge clk);
      if (tx_oe && prev && !tx_out) begin
        repeat (BIT / 2) @(negedge clk);
        chk("R3 start bit", tx_out, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          got[i] = tx_out;
        end
        repeat (BIT) @(negedge clk);
        chk("R3 stop bit", tx_out, 1);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R3 unexpected frame: actual %0h expected none", got);
        end else begin
          exp = exp_q.pop_front();
          chk("R3 frame data", got, exp);
        end
      end
      prev = tx_out;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 tx_empty", tx_empty, 1);
    chk("R10 rx_ready", rx_ready, 0);
    chk("R10 frame_err", frame_err, 0);
    chk("R10 overrun", overrun, 0);
    chk("R10 tx_oe", tx_oe, 0);
    chk("R10 tx_out", tx_out, 1);
    chk("R10 rdata", host_rdata, 0);

    cfg(3'b011);
    chk("R1 tx_oe on", tx_oe, 1);
    hwrite(8'hA5);
    chk("R4 pending", tx_empty, 0);
    @(negedge clk);
    chk("R4 moved", tx_empty, 1);
    repeat (2 * BIT) @(negedge clk);
    hwrite(8'h01);
    chk("R4 second pending", tx_empty, 0);
    wait (tx_empty == 1'b0 || tx_empty == 1'b1);
    while (!tx_empty) @(negedge clk);
    hwrite(8'h80);
    repeat (24 * BIT) @(negedge clk);
    chk("R3 all sent", exp_q.size(), 0);

    cfg(3'b010);
    chk("R1 global off", tx_oe, 0);
    hwrite(8'h3C);
    repeat (3 * BIT) @(negedge clk);
    chk("R1 held pending", tx_empty, 0);
    chk("R1 line high", tx_out, 1);
    cfg(3'b011);
    repeat (12 * BIT) @(negedge clk);
    chk("R1 sent after enable", exp_q.size(), 0);

    cfg(3'b101);
    send(8'h5A, 1'b1);
    chk("R5 ready", rx_ready, 1);
    chk("R5 data", host_rdata, 8'h5A);
    chk("R5 no ferr", frame_err, 0);
    hread();
    chk("R6 ready cleared", rx_ready, 0);

    cfg(3'b001);
    send(8'hC3, 1'b1);
    chk("R2 ignored ready", rx_ready, 0);
    chk("R2 ignored data", host_rdata, 8'h5A);

    cfg(3'b101);
    send(8'h96, 1'b0);
    chk("R7 ferr", frame_err, 1);
    chk("R7 ready", rx_ready, 1);
    chk("R7 data", host_rdata, 8'h96);
    repeat (2 * BIT) @(negedge clk);
    hread();
    chk("R6 ferr cleared", frame_err, 0);

    send(8'h12, 1'b1);
    send(8'h34, 1'b1);
    chk("R8 overrun", overrun, 1);
    chk("R8 newest kept", host_rdata, 8'h34);
    hread();
    chk("R6 overrun cleared", overrun, 0);

    hwrite(8'h11);
    send(8'h77, 1'b1);
    chk("R9 not copied", rx_ready, 0);
    chk("R9 host byte kept", host_rdata, 8'h11);
    chk("R9 still pending", tx_empty, 0);
    cfg(3'b111);
    repeat (3) @(negedge clk);
    chk("R9 host byte moved", tx_empty, 1);
    chk("R9 copied after", rx_ready, 1);
    chk("R9 rx data", host_rdata, 8'h77);
    repeat (12 * BIT) @(negedge clk);
    chk("R9 host byte sent", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule